// File: doc/BRIEF.md
# Best Pending Interrupt Tracker

This block keeps, for a single processor, a record of the most urgent pending interrupt: its identifier, an 8-bit priority and a group code. A lower priority value means a more urgent interrupt, and the value 0xFF means that nothing is pending. The tracker does not hold the interrupt state itself. It walks an external bank one identifier per clock. For each identifier it reads a 32-bit word of eligibility flags, plus that identifier's priority, group and a flag that says whether it is routed to an implemented CPU.

Software-side logic asks for one of two scans. A partial scan covers an inclusive identifier window after something in that window has changed. A complete scan rebuilds the record from nothing. At the end of every scan, one message-based candidate that arrives on separate inputs can also take the record, but only when its gating conditions hold.

A partial scan is cheap. It escalates on its own to a complete scan only when the earlier winner sat inside the window and nothing found in the window was at least as good. In that case the earlier winner may have lost priority or stopped pending. While any scan is running, `busy_o` is high and a new request is not accepted. Requesters hold `req_i` until `busy_o` is low.

Top module: `hppi_select`

## Requirements
- R1: A candidate replaces the record when its priority value is numerically lower than the recorded priority.
- R2: When the priorities are equal, a candidate whose ID is lower than or equal to the recorded ID replaces it, so the lowest ID wins among ties.
- R3: After reset the priority output is 0xFF, the valid output is 0 and busy is 0. A complete scan first clears the recorded priority to 0xFF, so with nothing eligible it ends with priority 0xFF and valid 0.
- R4: If a partial scan finds no candidate at least as good as the record, and the earlier winner's ID lies inside the window with a priority other than 0xFF, a complete scan follows within the same busy period.
- R5: If a partial scan finds no such candidate and the earlier winner lies outside the window, the record is unchanged. The record is also unchanged while the block is idle with no request.
- R6: The message-based candidate is compared at the end of a scan only when all of the following hold: `lpi_en_i` is 1, `grp1ns_en_i` is 1, and `lpi_pri_i` is not 0xFF. It wins under the rules of R1 and R2.
- R7: `chunk_idx_o` equals the scanned ID divided by 32. Eligibility bit (ID mod 32) of `chunk_bits_i` belongs to the scanned ID. The word is captured at the first ID of a scan and at every ID that is a multiple of 32, so windows that cross a 32-ID boundary are handled.
- R8: An eligible ID whose `scan_routed_i` is 0 is never selected.
- R9: The group output takes the group of the candidate only when that candidate replaces the record. For an ID from the bank this is `scan_grp_i`; for the message-based candidate it is `lpi_grp_i`.
- R10: A partial scan of N IDs with no escalation keeps `busy_o` high for N+1 cycles, and the first scanned ID equals the window's low bound. A request raised while busy is not accepted.
- R11: While idle, `best_valid_o` equals (`best_pri_o` != 0xFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Scan request, accepted when busy_o is low |
| req_full_i | input | 1 | 1 selects a complete scan, 0 a partial scan |
| req_lo_i | input | ID_W | Low bound of the partial window (inclusive) |
| req_hi_i | input | ID_W | High bound of the partial window (inclusive, not below low) |
| busy_o | output | 1 | High for the whole scan |
| chunk_idx_o | output | CIDX_W | Index of the 32-ID eligibility word wanted |
| chunk_bits_i | input | CHUNK_W | Eligibility word for chunk_idx_o |
| scan_id_o | output | ID_W | ID currently being scanned |
| scan_pri_i | input | PRI_W | Priority of scan_id_o |
| scan_grp_i | input | GRP_W | Group of scan_id_o |
| scan_routed_i | input | 1 | scan_id_o targets an implemented CPU |
| lpi_en_i | input | 1 | Message-based interrupts enabled |
| grp1ns_en_i | input | 1 | Non-secure group 1 enabled |
| lpi_id_i | input | ID_W | Message-based candidate ID |
| lpi_pri_i | input | PRI_W | Message-based candidate priority |
| lpi_grp_i | input | GRP_W | Message-based candidate group |
| best_id_o | output | ID_W | Recorded winner ID |
| best_pri_o | output | PRI_W | Recorded winner priority (0xFF means none) |
| best_grp_o | output | GRP_W | Recorded winner group |
| best_valid_o | output | 1 | A winner is recorded |

## Verification
The hardest case to reach from the ports is escalation. It needs a recorded winner that then stops pending or drops in priority without leaving its window, after which a partial scan over that window must run. The stimulus table builds this on purpose. It first records a winner, then clears its eligibility bit in one vector and raises its priority value in another. Each time it requests a partial scan that covers only the old winner's window. The expected result is the best of the IDs outside that window, which only a complete scan can find. Unrouted high-urgency IDs, chunk-crossing windows and equal-priority ties are placed in the same table, so every vector depends on state left by the vectors before it.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_LPI  = 2'd2
  } scan_state_t;
endpackage

// File: rtl/hppi_better.sv
// Precedence test: lower priority value wins; equal priority wins on lower-or-equal ID.
module hppi_better #(
  parameter int ID_W  = 16,
  parameter int PRI_W = 8
) (
  input  logic [PRI_W-1:0] cand_pri,
  input  logic [ID_W-1:0]  cand_id,
  input  logic [PRI_W-1:0] rec_pri,
  input  logic [ID_W-1:0]  rec_id,
  output logic             wins
);
  always_comb begin
    wins = (cand_pri < rec_pri) || ((cand_pri == rec_pri) && (cand_id <= rec_id));
  end
endmodule

// File: rtl/hppi_chunk_buf.sv
// Holds one eligibility word; on a load cycle the incoming word is used directly.
module hppi_chunk_buf #(
  parameter int CHUNK_W = 32,
  localparam int SUB_W  = $clog2(CHUNK_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CHUNK_W-1:0] bits_in,
  input  logic [SUB_W-1:0]   sel,
  output logic               bit_out
);
  logic [CHUNK_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= bits_in;
  end

  always_comb begin
    bit_out = load ? bits_in[sel] : word_q[sel];
  end
endmodule

// File: rtl/hppi_select.sv
module hppi_select
  import hppi_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 16,
  parameter int PRI_W   = 8,
  parameter int GRP_W   = 2,
  parameter int CHUNK_W = 32,
  localparam int SUB_W  = $clog2(CHUNK_W),
  localparam int NCHUNK = NUM_IDS / CHUNK_W,
  localparam int CIDX_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_i,
  input  logic               req_full_i,
  input  logic [ID_W-1:0]    req_lo_i,
  input  logic [ID_W-1:0]    req_hi_i,
  output logic               busy_o,
  output logic [CIDX_W-1:0]  chunk_idx_o,
  input  logic [CHUNK_W-1:0] chunk_bits_i,
  output logic [ID_W-1:0]    scan_id_o,
  input  logic [PRI_W-1:0]   scan_pri_i,
  input  logic [GRP_W-1:0]   scan_grp_i,
  input  logic               scan_routed_i,
  input  logic               lpi_en_i,
  input  logic               grp1ns_en_i,
  input  logic [ID_W-1:0]    lpi_id_i,
  input  logic [PRI_W-1:0]   lpi_pri_i,
  input  logic [GRP_W-1:0]   lpi_grp_i,
  output logic [ID_W-1:0]    best_id_o,
  output logic [PRI_W-1:0]   best_pri_o,
  output logic [GRP_W-1:0]   best_grp_o,
  output logic               best_valid_o
);
  localparam logic [PRI_W-1:0] PRI_NONE = {PRI_W{1'b1}};
  localparam logic [ID_W-1:0]  ID_LAST  = ID_W'(NUM_IDS - 1);

  scan_state_t      st_q;
  logic [ID_W-1:0]  cur_q, lo_q, hi_q, old_id_q, best_id_q;
  logic [PRI_W-1:0] old_pri_q, best_pri_q;
  logic [GRP_W-1:0] best_grp_q;
  logic             first_q, full_q, seen_q, valid_q;

  // eligibility word capture at scan start and at each 32-ID boundary
  logic chunk_load, elig_bit;
  assign chunk_load = (st_q == ST_SCAN) && (first_q || (cur_q[SUB_W-1:0] == '0));

  hppi_chunk_buf #(.CHUNK_W(CHUNK_W)) u_chunk (
    .clk     (clk),
    .rst     (rst),
    .load    (chunk_load),
    .bits_in (chunk_bits_i),
    .sel     (cur_q[SUB_W-1:0]),
    .bit_out (elig_bit)
  );

  // precedence for the scanned ID and for the message-based candidate
  logic scan_wins, lpi_wins;
  hppi_better #(.ID_W(ID_W), .PRI_W(PRI_W)) u_cmp_scan (
    .cand_pri (scan_pri_i), .cand_id (cur_q),
    .rec_pri  (best_pri_q), .rec_id  (best_id_q),
    .wins     (scan_wins)
  );
  hppi_better #(.ID_W(ID_W), .PRI_W(PRI_W)) u_cmp_lpi (
    .cand_pri (lpi_pri_i),  .cand_id (lpi_id_i),
    .rec_pri  (best_pri_q), .rec_id  (best_id_q),
    .wins     (lpi_wins)
  );

  logic scan_take, lpi_take, seen_final, escalate, old_in_win;
  always_comb begin
    scan_take  = (st_q == ST_SCAN) && elig_bit && scan_routed_i && scan_wins;
    lpi_take   = (st_q == ST_LPI) && lpi_en_i && grp1ns_en_i &&
                 (lpi_pri_i != PRI_NONE) && lpi_wins;
    seen_final = seen_q || lpi_take;
    old_in_win = (old_id_q >= lo_q) && (old_id_q <= hi_q);
    escalate   = (st_q == ST_LPI) && !full_q && !seen_final &&
                 (old_pri_q != PRI_NONE) && old_in_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cur_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      old_id_q   <= '0;
      old_pri_q  <= PRI_NONE;
      best_id_q  <= '0;
      best_pri_q <= PRI_NONE;
      best_grp_q <= '0;
      first_q    <= 1'b0;
      full_q     <= 1'b0;
      seen_q     <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            st_q      <= ST_SCAN;
            first_q   <= 1'b1;
            seen_q    <= 1'b0;
            old_id_q  <= best_id_q;
            old_pri_q <= best_pri_q;
            if (req_full_i) begin
              cur_q      <= '0;
              lo_q       <= '0;
              hi_q       <= ID_LAST;
              full_q     <= 1'b1;
              best_pri_q <= PRI_NONE;
            end else begin
              cur_q  <= req_lo_i;
              lo_q   <= req_lo_i;
              hi_q   <= req_hi_i;
              full_q <= 1'b0;
            end
          end
        end
        ST_SCAN: begin
          first_q <= 1'b0;
          if (scan_take) begin
            best_id_q  <= cur_q;
            best_pri_q <= scan_pri_i;
            best_grp_q <= scan_grp_i;
            seen_q     <= 1'b1;
          end
          if (cur_q == hi_q) st_q  <= ST_LPI;
          else               cur_q <= cur_q + ID_W'(1);
        end
        ST_LPI: begin
          if (escalate) begin
            st_q       <= ST_SCAN;
            first_q    <= 1'b1;
            seen_q     <= 1'b0;
            cur_q      <= '0;
            lo_q       <= '0;
            hi_q       <= ID_LAST;
            full_q     <= 1'b1;
            best_pri_q <= PRI_NONE;
          end else begin
            st_q <= ST_IDLE;
            if (lpi_take) begin
              best_id_q  <= lpi_id_i;
              best_pri_q <= lpi_pri_i;
              best_grp_q <= lpi_grp_i;
            end
            valid_q <= ((lpi_take ? lpi_pri_i : best_pri_q) != PRI_NONE);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign scan_id_o    = cur_q;
  assign chunk_idx_o  = cur_q[SUB_W +: CIDX_W];
  assign best_id_o    = best_id_q;
  assign best_pri_o   = best_pri_q;
  assign best_grp_o   = best_grp_q;
  assign best_valid_o = valid_q;
endmodule

// File: rtl/hppi_select_chk.sv
module hppi_select_chk #(
  parameter int NUM_IDS = 64,
  parameter int ID_W    = 16,
  parameter int PRI_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_i,
  input logic             busy_o,
  input logic [ID_W-1:0]  scan_id_o,
  input logic [ID_W-1:0]  best_id_o,
  input logic [PRI_W-1:0] best_pri_o,
  input logic             best_valid_o
);
  localparam logic [PRI_W-1:0] PRI_NONE = {PRI_W{1'b1}};

  // R10: an accepted request starts a scan
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy_o) |=> busy_o);

  // R11: idle valid flag agrees with the recorded priority
  p_valid_agrees_r11: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (best_valid_o == (best_pri_o != PRI_NONE)));

  // R1: during a scan priority only improves, except a clear to 0xFF
  p_pri_improves_r1: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ((best_pri_o <= $past(best_pri_o)) || (best_pri_o == PRI_NONE)));

  // R7: scanned ID stays inside the bank
  p_scan_inside_r7: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (scan_id_o < ID_W'(NUM_IDS)));

  // R5: record holds while idle with no request
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !req_i) |=> ($stable(best_id_o) && $stable(best_pri_o)));
endmodule

bind hppi_select hppi_select_chk #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .PRI_W(PRI_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_i        (req_i),
  .busy_o       (busy_o),
  .scan_id_o    (scan_id_o),
  .best_id_o    (best_id_o),
  .best_pri_o   (best_pri_o),
  .best_valid_o (best_valid_o)
);

// File: tb/tb_hppi_select.sv
`timescale 1ns/1ps
module tb_hppi_select;
  localparam int NUM_IDS = 64;
  localparam int ID_W    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_i = 1'b0, req_full_i = 1'b0;
  logic [15:0] req_lo_i = '0, req_hi_i = '0;
  logic        busy_o;
  logic [0:0]  chunk_idx_o;
  logic [31:0] chunk_bits_i;
  logic [15:0] scan_id_o;
  logic [7:0]  scan_pri_i;
  logic [1:0]  scan_grp_i;
  logic        scan_routed_i;
  logic        lpi_en_i = 1'b0, grp1ns_en_i = 1'b0;
  logic [15:0] lpi_id_i = '0;
  logic [7:0]  lpi_pri_i = 8'hFF;
  logic [1:0]  lpi_grp_i = '0;
  logic [15:0] best_id_o;
  logic [7:0]  best_pri_o;
  logic [1:0]  best_grp_o;
  logic        best_valid_o;

  hppi_select dut (.*);

  // bank model: group = ID mod 4; ID 40 is unrouted
  logic       elig  [NUM_IDS];
  logic [7:0] pri   [NUM_IDS];
  logic       route [NUM_IDS];

  always_comb begin
    for (int k = 0; k < 32; k++) chunk_bits_i[k] = elig[int'(chunk_idx_o) * 32 + k];
    scan_pri_i    = pri[scan_id_o[5:0]];
    scan_grp_i    = scan_id_o[1:0];
    scan_routed_i = route[scan_id_o[5:0]];
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a request at a negedge, count negedges with busy high
  task automatic run(input logic full, input logic [15:0] lo, input logic [15:0] hi,
                     output int cyc, output int first_id, output int first_chunk);
    @(negedge clk);
    req_i = 1'b1; req_full_i = full; req_lo_i = lo; req_hi_i = hi;
    @(negedge clk);
    req_i = 1'b0;
    cyc = 0; first_id = scan_id_o; first_chunk = chunk_idx_o;
    while (busy_o && cyc < 2000) begin
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 2000) chk("watchdog", cyc, 0);
  endtask

  typedef struct packed {
    logic [7:0]  sid;
    logic        sel;
    logic [7:0]  spri;
    logic        full;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [15:0] eid;
    logic [7:0]  epri;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'd10, 1'b1, 8'h40, 1'b0, 8'd8,  8'd15, 16'd10, 8'h40}, // R1 first win
    '{8'd20, 1'b1, 8'h40, 1'b0, 8'd16, 8'd31, 16'd10, 8'h40}, // R5 R2 tie higher id, outside
    '{8'd5,  1'b1, 8'h40, 1'b0, 8'd0,  8'd7,  16'd5,  8'h40}, // R2 tie lower id
    '{8'd50, 1'b1, 8'h10, 1'b0, 8'd30, 8'd55, 16'd50, 8'h10}, // R7 crosses 32
    '{8'd40, 1'b1, 8'h05, 1'b0, 8'd32, 8'd47, 16'd50, 8'h10}, // R8 unrouted
    '{8'd50, 1'b0, 8'h10, 1'b0, 8'd48, 8'd63, 16'd5,  8'h40}, // R4 winner gone
    '{8'd5,  1'b1, 8'h60, 1'b0, 8'd0,  8'd7,  16'd10, 8'h40}, // R4 winner demoted
    '{8'd10, 1'b0, 8'h40, 1'b1, 8'd0,  8'd0,  16'd20, 8'h40}, // R3 full
    '{8'd20, 1'b0, 8'h40, 1'b1, 8'd0,  8'd0,  16'd5,  8'h60}, // R3 full
    '{8'd5,  1'b0, 8'h60, 1'b1, 8'd0,  8'd0,  16'd0,  8'hFF}, // R3 full, none
    '{8'd63, 1'b1, 8'h20, 1'b0, 8'd63, 8'd63, 16'd63, 8'h20}, // R7 last id
    '{8'd0,  1'b1, 8'h20, 1'b0, 8'd0,  8'd0,  16'd0,  8'h20}  // R2 id 0 tie
  };

  initial begin
    int cyc, fid, fch;
    for (int i = 0; i < NUM_IDS; i++) begin
      elig[i] = 1'b0; pri[i] = 8'h80; route[i] = (i != 40);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset pri", best_pri_o, 8'hFF);
    chk("R3 reset valid", best_valid_o, 0);
    chk("R3 reset busy", busy_o, 0);

    for (int v = 0; v < 12; v++) begin
      elig[VEC[v].sid] = VEC[v].sel;
      pri[VEC[v].sid]  = VEC[v].spri;
      run(VEC[v].full, 16'(VEC[v].lo), 16'(VEC[v].hi), cyc, fid, fch);
      chk($sformatf("R1/R4 vec%0d pri", v), best_pri_o, VEC[v].epri);
      chk($sformatf("R11 vec%0d valid", v), best_valid_o, VEC[v].epri != 8'hFF);
      if (VEC[v].epri != 8'hFF) begin
        chk($sformatf("R2/R5 vec%0d id", v), best_id_o, VEC[v].eid);
        chk($sformatf("R9 vec%0d grp", v), best_grp_o, VEC[v].eid % 4);
      end
    end

    // R10 busy length, start id, chunk index, hold-off of a request raised while busy
    @(negedge clk);
    req_i = 1'b1; req_full_i = 1'b0; req_lo_i = 16'd30; req_hi_i = 16'd55;
    @(negedge clk);
    req_i = 1'b0;
    chk("R10 first id", scan_id_o, 30);
    chk("R7 chunk idx at 30", chunk_idx_o, 0);
    cyc = 0;
    while (busy_o && cyc < 2000) begin
      cyc++;
      if (cyc == 5) begin req_i = 1'b1; req_full_i = 1'b1; end
      if (cyc == 6) req_i = 1'b0;
      if (scan_id_o == 16'd40) chk("R7 chunk idx at 40", chunk_idx_o, 1);
      @(negedge clk);
    end
    chk("R10 busy cycles", cyc, 27);
    @(negedge clk);
    chk("R10 no late accept", busy_o, 0);
    chk("R5 record after", best_id_o, 0);

    // R6 message-based candidate
    lpi_en_i = 1'b1; grp1ns_en_i = 1'b1; lpi_id_i = 16'd1000; lpi_pri_i = 8'h10; lpi_grp_i = 2'd3;
    run(1'b0, 16'd63, 16'd63, cyc, fid, fch);
    chk("R6 lpi id", best_id_o, 1000);
    chk("R6 lpi pri", best_pri_o, 8'h10);
    chk("R9 lpi grp", best_grp_o, 3);
    grp1ns_en_i = 1'b0;
    run(1'b1, 16'd0, 16'd0, cyc, fid, fch);
    chk("R6 grp1ns off id", best_id_o, 0);
    chk("R6 grp1ns off pri", best_pri_o, 8'h20);
    grp1ns_en_i = 1'b1; lpi_pri_i = 8'hFF;
    run(1'b1, 16'd0, 16'd0, cyc, fid, fch);
    chk("R6 lpi pri none", best_id_o, 0);
    lpi_pri_i = 8'h20;
    run(1'b1, 16'd0, 16'd0, cyc, fid, fch);
    chk("R2 lpi tie higher id", best_id_o, 0);
    lpi_en_i = 1'b0; lpi_pri_i = 8'h01;
    run(1'b1, 16'd0, 16'd0, cyc, fid, fch);
    chk("R6 lpi disabled", best_pri_o, 8'h20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule